// File: doc/BRIEF.md
# Transceiver power-mode controller

This block decides which parts of a radio transceiver receive power. It combines a stored set of configuration bits with external control pins. From them it produces registered enable flags for the receive section, the transmit section and the frequency synthesizer. It also drives three general-purpose CMOS output pins. Two of those pins are bidirectional: in software mode they carry configuration bits out of the chip, and in hardwire mode they become power-down inputs for the receive and transmit sections.

The configuration word is 18 bits wide and is treated as synchronous to `clk`. The chip-enable pin, the synthesizer power-down pin and the two bidirectional pin inputs are asynchronous. Each passes through a synchronizer of `SYNC_STAGES` flops before it is used. A rising edge on chip enable also produces a one-cycle pulse that tells the divider counters to reload their programmed ratios.

The configuration bits are numbered from bit 0, the first function bit. The block uses these bits:

| Bit(s) | Meaning |
|---|---|
| 5 | Receive power-down |
| 6 | Transmit power-down |
| 7 | Level of output 0 |
| 8 | Level of output 1 |
| 9 | Level of output 2 |
| 11:10 | Mode field, with bit 11 as the upper bit |

The mode codes are 00 for software mode, 11 for hardwire mode, and 01 or 10 for test mode.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, every output is 0. The outputs are `rx_en`, `tx_en`, `pll_en`, `out0_val`, `out1_val`, `out1_oe`, `out2_val`, `out2_oe` and `cnt_reload`.
- R2: When the synchronized `chip_en` is 0, `rx_en`, `tx_en` and `pll_en` are all 0, whatever the configuration word and the other pins hold.
- R3: In software mode (`cfg[11:10]`=00) with chip enable high, `rx_en` is the inverse of `cfg[5]` and `tx_en` is the inverse of `cfg[6]`. A 1 in either bit powers that section down.
- R4: `out0_val` equals `cfg[7]` in every mode. In software mode and in test mode, `out1_val` equals `cfg[8]`, `out2_val` equals `cfg[9]`, and `out1_oe` and `out2_oe` are 1.
- R5: In hardwire mode (`cfg[11:10]`=11), `out1_oe` and `out2_oe` are 0, and `out1_val` and `out2_val` still follow `cfg[8]` and `cfg[9]`. With chip enable high, `rx_en` is the inverse of the synchronized `io1_in` and `tx_en` is the inverse of the synchronized `io2_in`.
- R6: In every mode, `pll_en` is 1 exactly when chip enable is high and the synchronized `pll_pd` is 0.
- R7: In test mode (`cfg[11:10]`=01 or 10), `rx_en` and `tx_en` are 0.
- R8: A 0-to-1 change of `chip_en` gives `cnt_reload`=1 for exactly one cycle. This happens on the third rising clock edge after the change, which is the same edge on which the enables first reflect chip enable high. With the default of two synchronizer stages, a pin change reaches the enables on the third edge, and a change of `cfg` reaches them on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable pin (asynchronous) |
| pll_pd | input | 1 | Hardwire synthesizer power-down pin (asynchronous) |
| io1_in | input | 1 | Input value of bidirectional pin 1, the receive power-down in hardwire mode |
| io2_in | input | 1 | Input value of bidirectional pin 2, the transmit power-down in hardwire mode |
| cfg | input | 18 | Configuration word from the function latch |
| rx_en | output | 1 | Receive section enable |
| tx_en | output | 1 | Transmit section enable |
| pll_en | output | 1 | Synthesizer section enable |
| out0_val | output | 1 | Drive level of output pin 0 |
| out1_val | output | 1 | Drive level of bidirectional pin 1 |
| out1_oe | output | 1 | Output enable of bidirectional pin 1 |
| out2_val | output | 1 | Drive level of bidirectional pin 2 |
| out2_oe | output | 1 | Output enable of bidirectional pin 2 |
| cnt_reload | output | 1 | One-cycle pulse that reloads the divider counters |

## Verification
The hardest case to reach from the ports is the interaction between the mode field and the pin inputs. In hardwire mode, the bidirectional pins must govern the enables while the configuration power-down bits are ignored, and in software mode the reverse must hold. The stimulus therefore sweeps every combination of chip enable, synthesizer power-down, both pin inputs and configuration bits 5 to 11. The unused configuration bits are set to a varying pattern, so any crossover between the pin path and the configuration path shows up. The reload pulse is checked separately by stepping chip enable at a known clock phase and sampling on each of the following four edges.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int CFG_W   = 18;
  localparam int B_RXPD  = 5;
  localparam int B_TXPD  = 6;
  localparam int B_OUT0  = 7;
  localparam int B_OUT1  = 8;
  localparam int B_OUT2  = 9;
  localparam int B_MODE0 = 10;
  localparam int B_MODE1 = 11;

  typedef enum logic [1:0] {
    MODE_SW  = 2'b00,
    MODE_TA  = 2'b01,
    MODE_TB  = 2'b10,
    MODE_HW  = 2'b11
  } pm_mode_e;

  typedef struct packed {
    logic rx_en;
    logic tx_en;
    logic pll_en;
    logic out0;
    logic out1;
    logic out1_oe;
    logic out2;
    logic out2_oe;
  } pm_out_t;

  function automatic pm_mode_e mode_of(logic [CFG_W-1:0] c);
    return pm_mode_e'({c[B_MODE1], c[B_MODE0]});
  endfunction

  function automatic pm_out_t decode(logic ce, logic pllpd, logic rxpd_pin,
                                     logic txpd_pin, logic [CFG_W-1:0] c);
    pm_out_t o;
    pm_mode_e m;
    m = mode_of(c);
    o.out0    = c[B_OUT0];
    o.out1    = c[B_OUT1];
    o.out2    = c[B_OUT2];
    o.out1_oe = (m != MODE_HW);
    o.out2_oe = (m != MODE_HW);
    o.pll_en  = ce & ~pllpd;
    case (m)
      MODE_SW: begin
        o.rx_en = ce & ~c[B_RXPD];
        o.tx_en = ce & ~c[B_TXPD];
      end
      MODE_HW: begin
        o.rx_en = ce & ~rxpd_pin;
        o.tx_en = ce & ~txpd_pin;
      end
      default: begin
        o.rx_en = 1'b0;
        o.tx_en = 1'b0;
      end
    endcase
    return o;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[LAST];
  end
endmodule

// File: rtl/ce_edge.sv
module ce_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_s,
  output logic reload
);
  logic ce_prev;
  logic rise;

  assign rise = ce_s & ~ce_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_prev <= 1'b0;
      reload  <= 1'b0;
    end else begin
      ce_prev <= ce_s;
      reload  <= rise;
    end
  end

  AST_RELOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !reload); // R8
  AST_RELOAD_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    reload |-> $past(ce_s)); // R8
endmodule

// File: rtl/enable_decode.sv
module enable_decode
  import pwr_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_s,
  input  logic             pllpd_s,
  input  logic             rxpd_s,
  input  logic             txpd_s,
  input  logic [CFG_W-1:0] cfg,
  output pm_out_t          q
);
  pm_mode_e mode_now;
  assign mode_now = mode_of(cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= decode(ce_s, pllpd_s, rxpd_s, txpd_s, cfg);
  end

  AST_CE_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> (!q.rx_en && !q.tx_en && !q.pll_en)); // R2
  AST_TEST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == MODE_TA || mode_now == MODE_TB) |=> (!q.rx_en && !q.tx_en)); // R7
  AST_HW_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == MODE_HW) |=> (!q.out1_oe && !q.out2_oe)); // R5
  AST_PLL_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    pllpd_s |=> !q.pll_en); // R6
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en,
  input  logic             pll_pd,
  input  logic             io1_in,
  input  logic             io2_in,
  input  logic [CFG_W-1:0] cfg,
  output logic             rx_en,
  output logic             tx_en,
  output logic             pll_en,
  output logic             out0_val,
  output logic             out1_val,
  output logic             out1_oe,
  output logic             out2_val,
  output logic             out2_oe,
  output logic             cnt_reload
);
  localparam int NPINS = 4;

  logic [NPINS-1:0] pins_s;
  logic ce_s, pllpd_s, rxpd_s, txpd_s;
  pm_out_t st;

  pin_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({chip_en, pll_pd, io1_in, io2_in}),
    .q(pins_s)
  );
  assign {ce_s, pllpd_s, rxpd_s, txpd_s} = pins_s;

  ce_edge u_edge (.clk(clk), .rst_n(rst_n), .ce_s(ce_s), .reload(cnt_reload));

  enable_decode u_dec (
    .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .pllpd_s(pllpd_s),
    .rxpd_s(rxpd_s), .txpd_s(txpd_s), .cfg(cfg), .q(st)
  );

  assign rx_en    = st.rx_en;
  assign tx_en    = st.tx_en;
  assign pll_en   = st.pll_en;
  assign out0_val = st.out0;
  assign out1_val = st.out1;
  assign out1_oe  = st.out1_oe;
  assign out2_val = st.out2;
  assign out2_oe  = st.out2_oe;

  AST_RELOAD_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_reload |-> (pll_en || $past(pllpd_s))); // R8
endmodule

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en = 1'b0, pll_pd = 1'b0, io1_in = 1'b0, io2_in = 1'b0;
  logic [17:0] cfg = '0;
  logic rx_en, tx_en, pll_en, out0_val, out1_val, out1_oe, out2_val, out2_oe, cnt_reload;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_mode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .pll_pd(pll_pd),
    .io1_in(io1_in), .io2_in(io2_in), .cfg(cfg),
    .rx_en(rx_en), .tx_en(tx_en), .pll_en(pll_en), .out0_val(out0_val),
    .out1_val(out1_val), .out1_oe(out1_oe), .out2_val(out2_val),
    .out2_oe(out2_oe), .cnt_reload(cnt_reload)
  );

  function automatic logic [8:0] actual();
    return {rx_en, tx_en, pll_en, out0_val, out1_val, out1_oe, out2_val, out2_oe, cnt_reload};
  endfunction

  // Expected vector from the requirements, same order as actual().
  function automatic logic [8:0] model(logic ce, logic pd, logic p1, logic p2,
                                       logic [17:0] c, logic rl);
    int mode;
    logic rx, tx, hw;
    mode = c[11] * 2 + c[10];
    hw = (mode == 3);
    if (!ce)            begin rx = 0; tx = 0; end              // R2
    else if (mode == 0) begin rx = !c[5]; tx = !c[6]; end      // R3
    else if (hw)        begin rx = !p1; tx = !p2; end          // R5
    else                begin rx = 0; tx = 0; end              // R7
    return {rx, tx, ce && !pd, c[7], c[8], !hw, c[9], !hw, rl}; // R4 R6
  endfunction

  task automatic check(string tag, logic [8:0] exp);
    n_vec++;
    if (actual() !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, actual(), exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  initial begin
    #5;
    check("R1 reset", 9'b0);
    tick(2);
    check("R1 reset held", 9'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6 R7: sweep over pins and cfg bits 5..11
    for (int v = 0; v < 2048; v++) begin
      @(negedge clk);
      chip_en = v[10]; pll_pd = v[9]; io1_in = v[8]; io2_in = v[7];
      cfg = '0;
      cfg[11:5] = v[6:0];
      cfg[4:0]   = 5'(v * 7);
      cfg[17:12] = 6'(v * 13 + 5);
      tick(4);
      check("R2-R7 sweep", model(chip_en, pll_pd, io1_in, io2_in, cfg, 1'b0));
    end

    // R8: reload pulse timing, software mode, both sections up
    for (int rep = 0; rep < 4; rep++) begin
      @(negedge clk);
      chip_en = 1'b0; pll_pd = rep[0]; io1_in = 1'b0; io2_in = 1'b0;
      cfg = '0; cfg[7] = rep[1];
      tick(5);
      check("R8 idle low", model(1'b0, pll_pd, 1'b0, 1'b0, cfg, 1'b0));
      @(negedge clk);
      chip_en = 1'b1;
      tick(1);
      check("R8 edge1", model(1'b0, pll_pd, 1'b0, 1'b0, cfg, 1'b0));
      tick(1);
      check("R8 edge2", model(1'b0, pll_pd, 1'b0, 1'b0, cfg, 1'b0));
      tick(1);
      check("R8 edge3 pulse", model(1'b1, pll_pd, 1'b0, 1'b0, cfg, 1'b1));
      tick(1);
      check("R8 edge4 clear", model(1'b1, pll_pd, 1'b0, 1'b0, cfg, 1'b0));
      tick(3);
      check("R8 no repeat", model(1'b1, pll_pd, 1'b0, 1'b0, cfg, 1'b0));
    end

    // R8: cfg change reaches enables on the next edge
    @(negedge clk);
    cfg[5] = 1'b1;
    tick(1);
    check("R8 cfg latency", model(1'b1, pll_pd, 1'b0, 1'b0, cfg, 1'b0));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule